// File: doc/BRIEF.md
# Pointer-versus-data word receiver

This block sits on the receive side of a word-at-a-time request/acknowledge link. Each time the sender places a 16-bit word on the link and the local side sees the request flag rise, the word is offered to the block with a one-cycle valid strobe. The block reads the level of the request flag in that same cycle to decide what the word is. If the flag is still high, the sender is holding it for an acknowledgement, and the word is part of a destination address. If the flag has already fallen, the sender pulsed it, and the word is payload.

Two address words make a 32-bit pointer. The upper half comes first and the lower half second. A one-bit half selector tracks which half comes next. Each payload word is written to memory at the current pointer, and the pointer then moves on by one 16-bit word, which is two byte addresses. Every word taken is acknowledged with a single-cycle pulse. Payload that arrives before any full pointer has been loaded is discarded, counted, and still acknowledged.

Top module: `ptr_word_rx`

## Requirements
- R1: After reset, mem_we_o, ack_o, drop_cnt_o, mem_addr_o and mem_data_o are all zero, and no pointer is loaded.
- R2: A word whose strobe cycle has req_i high is an address word. It never causes a memory write.
- R3: The first address word after reset, or after a completed pointer, is the upper 16 bits of the pointer. The next address word is the lower 16 bits. The next payload word is written at {upper, lower}.
- R4: The half selector returns to "upper" once the lower half is taken, so a third address word starts a new pointer.
- R5: A word whose strobe cycle has req_i low is a payload word. With a pointer loaded, mem_we_o is high for exactly the one cycle after the strobe edge. In that cycle mem_data_o is the word and mem_addr_o is the pointer.
- R6: After each payload write the pointer advances by STEP (default 2), wrapping modulo 2^32. Back-to-back writes therefore show addresses STEP apart.
- R7: A new pointer takes effect only when its lower half arrives. A payload word that arrives between the two halves is written at the old, advanced pointer.
- R8: A payload word that arrives before any complete pointer is not written. Instead it increments drop_cnt_o, which saturates at its all-ones value.
- R9: Every word taken, whether address, payload or dropped, produces exactly one ack_o pulse one cycle wide. The pulse comes two cycles after the strobe edge, which is one cycle after the write enable would appear.
- R10: Payload after a newly completed pointer is written at the new base, not at the old advanced pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | DW (16) | Word from the link |
| req_i | input | 1 | Level of the request flag |
| word_vld_i | input | 1 | One-cycle strobe: take word_i this cycle |
| mem_addr_o | output | 2*DW (32) | Memory write byte address |
| mem_data_o | output | DW (16) | Memory write data |
| mem_we_o | output | 1 | Memory write enable, one cycle per payload word |
| ack_o | output | 1 | Acknowledge pulse back to the sender |
| drop_cnt_o | output | CNT_W (8) | Saturating count of dropped payload words |

## Verification
The bench goes after payload that arrives with no pointer loaded. A design that got this wrong would write to address zero, or leave the word unacknowledged, or let the drop count wrap back to zero once full. It also inserts payload between the two address halves. A design that switched pointers early would write at a mixed address such as {new upper, old lower}. Back-to-back payload bursts and a pointer near the top of the address space test the advance step and the wrap. A design that advanced on address words, or by one, would show the wrong addresses there. Acknowledge counts are compared with words sent, which catches a design that acknowledges only payload.

// File: rtl/ptr_rx_pkg.sv
package ptr_rx_pkg;
  typedef enum logic [2:0] {
    KIND_IDLE,
    KIND_ADDR_HI,
    KIND_ADDR_LO,
    KIND_DATA,
    KIND_DROP
  } word_kind_e;
endpackage

// File: rtl/ptr_rx_classify.sv
module ptr_rx_classify
  import ptr_rx_pkg::*;
(
  input  logic       vld_i,
  input  logic       req_i,
  input  logic       half_lo_i,
  input  logic       ptr_vld_i,
  output word_kind_e kind_o
);
  always_comb begin
    kind_o = KIND_IDLE;
    if (vld_i) begin
      if (req_i)          kind_o = half_lo_i ? KIND_ADDR_LO : KIND_ADDR_HI;
      else if (ptr_vld_i) kind_o = KIND_DATA;
      else                kind_o = KIND_DROP;
    end
  end
endmodule

// File: rtl/ptr_rx_pointer.sv
module ptr_rx_pointer
  import ptr_rx_pkg::*;
#(
  parameter int DW   = 16,
  parameter int STEP = 2,
  localparam int AW  = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  word_kind_e    kind_i,
  input  logic [DW-1:0] word_i,
  output logic [AW-1:0] ptr_o,
  output logic          ptr_vld_o,
  output logic          half_lo_o
);
  logic [DW-1:0] hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q      <= '0;
      ptr_o     <= '0;
      ptr_vld_o <= 1'b0;
      half_lo_o <= 1'b0;
    end else begin
      unique case (kind_i)
        KIND_ADDR_HI: begin
          hi_q      <= word_i;
          half_lo_o <= 1'b1;
        end
        KIND_ADDR_LO: begin
          ptr_o     <= {hi_q, word_i};
          ptr_vld_o <= 1'b1;
          half_lo_o <= 1'b0;
        end
        KIND_DATA: ptr_o <= ptr_o + AW'(STEP);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ptr_rx_emit.sv
module ptr_rx_emit
  import ptr_rx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CNT_W = 8,
  localparam int AW   = 2 * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  word_kind_e       kind_i,
  input  logic [DW-1:0]    word_i,
  input  logic [AW-1:0]    ptr_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_data_o,
  output logic             mem_we_o,
  output logic             ack_o,
  output logic [CNT_W-1:0] drop_cnt_o
);
  logic ack_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      mem_data_o <= '0;
      mem_we_o   <= 1'b0;
      ack_pend_q <= 1'b0;
      ack_o      <= 1'b0;
      drop_cnt_o <= '0;
    end else begin
      mem_we_o   <= (kind_i == KIND_DATA);
      ack_pend_q <= (kind_i != KIND_IDLE);
      ack_o      <= ack_pend_q;
      if (kind_i == KIND_DATA) begin
        mem_addr_o <= ptr_i;
        mem_data_o <= word_i;
      end
      // saturate rather than wrap
      if (kind_i == KIND_DROP && drop_cnt_o != '1)
        drop_cnt_o <= drop_cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ptr_word_rx.sv
module ptr_word_rx
  import ptr_rx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int STEP  = 2,
  parameter int CNT_W = 8,
  localparam int AW   = 2 * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    word_i,
  input  logic             req_i,
  input  logic             word_vld_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_data_o,
  output logic             mem_we_o,
  output logic             ack_o,
  output logic [CNT_W-1:0] drop_cnt_o
);
  word_kind_e    kind;
  logic [AW-1:0] ptr;
  logic          ptr_vld;
  logic          half_lo;

  ptr_rx_classify u_cls (
    .vld_i    (word_vld_i),
    .req_i    (req_i),
    .half_lo_i(half_lo),
    .ptr_vld_i(ptr_vld),
    .kind_o   (kind)
  );

  ptr_rx_pointer #(.DW(DW), .STEP(STEP)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (kind),
    .word_i   (word_i),
    .ptr_o    (ptr),
    .ptr_vld_o(ptr_vld),
    .half_lo_o(half_lo)
  );

  ptr_rx_emit #(.DW(DW), .CNT_W(CNT_W)) u_emit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kind_i    (kind),
    .word_i    (word_i),
    .ptr_i     (ptr),
    .mem_addr_o(mem_addr_o),
    .mem_data_o(mem_data_o),
    .mem_we_o  (mem_we_o),
    .ack_o     (ack_o),
    .drop_cnt_o(drop_cnt_o)
  );
endmodule

// File: rtl/ptr_rx_chk.sv
module ptr_rx_chk #(
  parameter int DW    = 16,
  parameter int STEP  = 2,
  parameter int CNT_W = 8,
  localparam int AW   = 2 * DW
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             word_vld_i,
  input logic [AW-1:0]    mem_addr_o,
  input logic             mem_we_o,
  input logic             ack_o,
  input logic [CNT_W-1:0] drop_cnt_o
);
  // R2
  addr_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_vld_i && req_i) |=> !mem_we_o);

  // R5
  write_from_payload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(word_vld_i && !req_i));

  // R6
  step_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && $past(mem_we_o)) |-> (mem_addr_o == $past(mem_addr_o) + AW'(STEP)));

  // R8
  drop_count_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o != $past(drop_cnt_o)) |-> (drop_cnt_o == $past(drop_cnt_o) + CNT_W'(1)));

  // R9
  ack_after_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_i |=> ##1 ack_o);

  // R9
  ack_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> ack_o);
endmodule

bind ptr_word_rx ptr_rx_chk #(.DW(DW), .STEP(STEP), .CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .word_vld_i(word_vld_i),
  .mem_addr_o(mem_addr_o),
  .mem_we_o  (mem_we_o),
  .ack_o     (ack_o),
  .drop_cnt_o(drop_cnt_o)
);

// File: tb/sim_ptr_word_rx.sv
`timescale 1ns/1ps
module sim_ptr_word_rx;
  localparam int CW = 3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] word = '0;
  logic        req = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] mem_addr;
  logic [15:0] mem_data;
  logic        mem_we;
  logic        ack;
  logic [CW-1:0] drop_cnt;

  int total = 0;
  int bad = 0;
  int sent = 0;
  int acks = 0;
  int writes = 0;
  logic [31:0] cap_addr = '0;
  logic [15:0] cap_data = '0;
  bit done = 0;

  // behavioural reference
  bit          m_pv = 0, m_half = 0, m_we = 0, m_ack = 0, m_pend = 0;
  logic [15:0] m_hi = '0, m_data = '0;
  logic [31:0] m_ptr = '0, m_addr = '0;
  int          m_drop = 0;

  always #4 clk = ~clk;

  ptr_word_rx #(.CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .word_i(word), .req_i(req), .word_vld_i(vld),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_we_o(mem_we),
    .ack_o(ack), .drop_cnt_o(drop_cnt)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_ni) begin
      m_we  = 0;
      m_ack = m_pend;
      m_pend = vld;
      if (vld) begin
        if (req) begin
          if (!m_half) begin m_hi = word; m_half = 1; end
          else begin m_ptr = {m_hi, word}; m_pv = 1; m_half = 0; end
        end else if (m_pv) begin
          m_we = 1; m_addr = m_ptr; m_data = word; m_ptr = m_ptr + 32'd2;
        end else if (m_drop < (1 << CW) - 1) m_drop++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(mem_we === m_we, "R5 we", 32'(mem_we), 32'(m_we));
      chk(ack === m_ack, "R9 ack", 32'(ack), 32'(m_ack));
      chk(drop_cnt === CW'(m_drop), "R8 drop", 32'(drop_cnt), 32'(m_drop));
      chk(mem_addr === m_addr, "R6 addr", mem_addr, m_addr);
      chk(mem_data === m_data, "R5 data", 32'(mem_data), 32'(m_data));
      if (mem_we) begin writes++; cap_addr = mem_addr; cap_data = mem_data; end
      if (ack) acks++;
    end
  end

  task automatic send(logic [15:0] w, bit is_addr);
    @(negedge clk);
    vld = 1; req = is_addr; word = w; sent++;
    @(negedge clk);
    vld = 0; req = 0;
  endtask

  task automatic burst(logic [15:0] w0, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld = 1; req = 0; word = w0 + 16'(i); sent++;
    end
    @(negedge clk);
    vld = 0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_we === 0 && ack === 0 && drop_cnt === 0 && mem_addr === 0 && mem_data === 0,
        "R1 reset", {mem_addr[15:0], mem_data}, 32'h0);
    rst_ni = 1;
    // payload with no pointer
    send(16'h1111, 0);
    settle();
    chk(writes == 0, "R8 no write", 32'(writes), 32'h0);
    chk(drop_cnt == 1, "R8 count", 32'(drop_cnt), 32'h1);
    for (int i = 0; i < 9; i++) send(16'h2222, 0);
    settle();
    chk(drop_cnt == 7, "R8 saturate", 32'(drop_cnt), 32'h7);
    // pointer halves
    send(16'h1234, 1);
    settle();
    chk(writes == 0, "R2 addr no write", 32'(writes), 32'h0);
    send(16'h5678, 1);
    send(16'hAAAA, 0);
    settle();
    chk(cap_addr == 32'h12345678, "R3 pointer", cap_addr, 32'h12345678);
    chk(cap_data == 16'hAAAA, "R5 data", 32'(cap_data), 32'hAAAA);
    burst(16'h0001, 3);
    settle();
    chk(cap_addr == 32'h1234567E, "R6 advance", cap_addr, 32'h1234567E);
    chk(writes == 4, "R6 writes", 32'(writes), 32'h4);
    // payload between halves
    send(16'hFFFF, 1);
    send(16'hBBBB, 0);
    settle();
    chk(cap_addr == 32'h12345680, "R7 old pointer", cap_addr, 32'h12345680);
    send(16'hFFFE, 1);
    send(16'hCCCC, 0);
    settle();
    chk(cap_addr == 32'hFFFFFFFE, "R10 new base", cap_addr, 32'hFFFFFFFE);
    send(16'hDDDD, 0);
    settle();
    chk(cap_addr == 32'h00000000, "R6 wrap", cap_addr, 32'h0);
    // toggle restarted: fresh pointer
    send(16'h00AB, 1);
    send(16'h0010, 1);
    burst(16'h0100, 2);
    settle();
    chk(cap_addr == 32'h00AB0012, "R4 new pointer", cap_addr, 32'h00AB0012);
    chk(acks == sent, "R9 ack count", 32'(acks), 32'(sent));
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule